// File: doc/BRIEF.md
# Fetch-Stage Next-Address Predictor

This block picks the address the front end fetches in the next cycle. Each cycle the current program counter goes into a direct-mapped table of branch records. Each record holds a valid flag, an address tag, the target the branch went to the last time it resolved taken, and a 2-bit saturating direction counter. A table hit is taken to mean the fetched instruction is a branch. The counter in the same record then decides whether the fetch follows the stored target or falls through to the next sequential instruction. Instructions are a fixed 4 bytes wide.

A separate resolve port reports branches that have executed. It gives the branch address, the target it computed and whether it was taken. A resolved branch that already has a record trains that record's counter. If it was taken, the record's target is also refreshed. A taken branch with no record gets a fresh one, which starts in the weakly-taken state. A not-taken branch with no record leaves the table alone. Lookup is purely combinational. Training is written on the next clock edge.

Top module: `fetch_next_pred`

## Requirements
- R1: When the lookup address has no matching valid record, `hit` and `predTaken` are 0 and `nextPc` equals `lookupPc + 4`.
- R2: The record index is `lookupPc[IDX_W+1:2]` and the tag is `lookupPc[ADDR_W-1:IDX_W+2]`. An address that selects an occupied index but carries a different tag misses.
- R3: On a hit, `predTaken` equals the record's counter bit 1. When that bit is 1, `nextPc` is the stored target. When it is 0, `hit` is 1 and `nextPc` is `lookupPc + 4`.
- R4: A taken resolve whose address misses creates a record with the reported target and the counter set to 2'b10 (weakly taken). A lookup of that address one cycle later hits, predicts taken and returns that target.
- R5: A not-taken resolve whose address misses changes no record. A later lookup of that address still misses.
- R6: The counter encoding is 11 strongly taken, 10 weakly taken, 01 weakly not-taken and 00 strongly not-taken. A resolve that hits adds 1 on taken and subtracts 1 on not-taken, saturating at 11 and 00.
- R7: From 11, a single not-taken resolve leaves the prediction taken and a second one turns it to not-taken. Symmetrically, from 00 one taken resolve keeps the prediction not-taken.
- R8: A taken resolve that hits replaces the stored target with the reported one. A not-taken resolve that hits leaves the target unchanged.
- R9: A resolve write takes effect at the next rising clock edge. A lookup of the same record in the same cycle returns the old contents.
- R10: A synchronous reset, active high, invalidates all records. A resolve presented in a reset cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lookupPc | input | ADDR_W | Address of the instruction being fetched |
| hit | output | 1 | A valid record matches `lookupPc` |
| predTaken | output | 1 | Record hit and predicted taken |
| nextPc | output | ADDR_W | Predicted next fetch address |
| resolveValid | input | 1 | A resolved branch is reported this cycle |
| resolvePc | input | ADDR_W | Address of the resolved branch |
| resolveTarget | input | ADDR_W | Target computed for the resolved branch |
| resolveTaken | input | 1 | Actual direction of the resolved branch |

## Verification
The embedded assertions watch, on every cycle, the port-visible effect of each kind of write:
- a fresh allocation is visible to a lookup of the same address one cycle later;
- a not-taken miss leaves that address missing;
- a saturated-high record stays saturated when trained taken again;
- the table is empty right after reset.

The walk of the counter through its four states only shows up in the bench's directed sequences, and so do the same-cycle read-before-write ordering and the preservation of the target on not-taken training. The random phase aims a small pool of aliasing addresses at a few indices, so that tag conflicts, evictions and retraining happen often.

// File: rtl/fetch_pred_pkg.sv
package fetch_pred_pkg;

  localparam logic [1:0] CTR_STRONG_NT = 2'b00;
  localparam logic [1:0] CTR_WEAK_T    = 2'b10;
  localparam logic [1:0] CTR_STRONG_T  = 2'b11;

  // Strobes from control to datapath for one resolve write.
  typedef struct packed {
    logic       wrEntry;   // write valid, tag and counter
    logic       wrTarget;  // also overwrite stored target
    logic [1:0] ctrVal;    // counter value to store
  } updStrobe_t;

  function automatic logic [1:0] satStep(input logic [1:0] cur, input logic up);
    logic [1:0] res;
    if (up) res = (cur == CTR_STRONG_T) ? cur : cur + 2'd1;
    else    res = (cur == CTR_STRONG_NT) ? cur : cur - 2'd1;
    return res;
  endfunction

endpackage

// File: rtl/fetch_pred_ctl.sv
module fetch_pred_ctl
  import fetch_pred_pkg::*;
(
  input  logic       rst,
  input  logic       resolveValid,
  input  logic       resolveTaken,
  input  logic       rsvHit,
  input  logic [1:0] rsvCtr,
  output updStrobe_t strb
);

  always_comb begin
    strb = '0;
    if (!rst && resolveValid) begin
      if (rsvHit) begin
        // train existing record; taken also refreshes target
        strb.wrEntry  = 1'b1;
        strb.wrTarget = resolveTaken;
        strb.ctrVal   = satStep(rsvCtr, resolveTaken);
      end else if (resolveTaken) begin
        // allocate fresh record in weakly-taken state
        strb.wrEntry  = 1'b1;
        strb.wrTarget = 1'b1;
        strb.ctrVal   = CTR_WEAK_T;
      end
    end
  end

endmodule

// File: rtl/fetch_pred_dp.sv
module fetch_pred_dp
  import fetch_pred_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] lookupPc,
  input  logic [ADDR_W-1:0] rsvPc,
  input  logic [ADDR_W-1:0] rsvTarget,
  input  updStrobe_t        strb,
  output logic              hit,
  output logic              predTaken,
  output logic [ADDR_W-1:0] nextPc,
  output logic              rsvHit,
  output logic [1:0]        rsvCtr
);

  localparam int ENTRIES = 1 << IDX_W;
  localparam int TAG_W   = ADDR_W - IDX_W - 2;
  localparam int TAG_LO  = IDX_W + 2;
  localparam logic [ADDR_W-1:0] INST_BYTES = ADDR_W'(4);

  logic              validQ  [ENTRIES];
  logic [TAG_W-1:0]  tagQ    [ENTRIES];
  logic [ADDR_W-1:0] targetQ [ENTRIES];
  logic [1:0]        ctrQ    [ENTRIES];

  logic [IDX_W-1:0] lkIdx, rsIdx;
  logic [TAG_W-1:0] lkTag, rsTag;

  assign lkIdx = lookupPc[TAG_LO-1:2];
  assign lkTag = lookupPc[ADDR_W-1:TAG_LO];
  assign rsIdx = rsvPc[TAG_LO-1:2];
  assign rsTag = rsvPc[ADDR_W-1:TAG_LO];

  // Lookup read port
  always_comb begin
    hit       = validQ[lkIdx] && (tagQ[lkIdx] == lkTag);
    predTaken = hit && ctrQ[lkIdx][1];
    nextPc    = predTaken ? targetQ[lkIdx] : lookupPc + INST_BYTES;
  end

  // Resolve read port, feeds the control
  always_comb begin
    rsvHit = validQ[rsIdx] && (tagQ[rsIdx] == rsTag);
    rsvCtr = ctrQ[rsIdx];
  end

  // Valid bits: reset-cleared
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) validQ[i] <= 1'b0;
    end else if (strb.wrEntry) begin
      validQ[rsIdx] <= 1'b1;
    end
  end

  // Record payload: no reset needed
  always_ff @(posedge clk) begin
    if (!rst && strb.wrEntry) begin
      tagQ[rsIdx] <= rsTag;
      ctrQ[rsIdx] <= strb.ctrVal;
      if (strb.wrTarget) targetQ[rsIdx] <= rsvTarget;
    end
  end

  // R10: table empty right after reset
  a_r10_reset_empty: assert property (@(posedge clk)
    $past(rst) |-> !hit);

  // R4: allocation visible on the following cycle
  a_r4_alloc_visible: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(strb.wrEntry && !rsvHit) && lookupPc == $past(rsvPc))
    |-> (hit && predTaken && nextPc == $past(rsvTarget)));

  // R6: strongly-taken record trained taken stays saturated
  a_r6_sat_high: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(strb.wrEntry && rsvHit && strb.wrTarget && rsvCtr == CTR_STRONG_T)
     && rsvPc == $past(rsvPc))
    |-> (rsvHit && rsvCtr == CTR_STRONG_T));

endmodule

// File: rtl/fetch_next_pred.sv
module fetch_next_pred
  import fetch_pred_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] lookupPc,
  output logic              hit,
  output logic              predTaken,
  output logic [ADDR_W-1:0] nextPc,
  input  logic              resolveValid,
  input  logic [ADDR_W-1:0] resolvePc,
  input  logic [ADDR_W-1:0] resolveTarget,
  input  logic              resolveTaken
);

  updStrobe_t strb;
  logic       rsvHit;
  logic [1:0] rsvCtr;

  fetch_pred_ctl u_ctl (
    .rst          (rst),
    .resolveValid (resolveValid),
    .resolveTaken (resolveTaken),
    .rsvHit       (rsvHit),
    .rsvCtr       (rsvCtr),
    .strb         (strb)
  );

  fetch_pred_dp #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .lookupPc  (lookupPc),
    .rsvPc     (resolvePc),
    .rsvTarget (resolveTarget),
    .strb      (strb),
    .hit       (hit),
    .predTaken (predTaken),
    .nextPc    (nextPc),
    .rsvHit    (rsvHit),
    .rsvCtr    (rsvCtr)
  );

  // R5: not-taken miss leaves the address missing
  a_r5_nt_miss_no_alloc: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(resolveValid && !resolveTaken && !rsvHit)
     && lookupPc == $past(resolvePc))
    |-> !hit);

endmodule

// File: tb/tb_fetch_next_pred.sv
module tb_fetch_next_pred;

  localparam int ADDR_W  = 32;
  localparam int IDX_W   = 4;
  localparam int ENTRIES = 1 << IDX_W;
  localparam int TAG_LO  = IDX_W + 2;

  logic              clk = 1'b0;
  logic              rst;
  logic [ADDR_W-1:0] lookupPc;
  logic              hit, predTaken;
  logic [ADDR_W-1:0] nextPc;
  logic              resolveValid;
  logic [ADDR_W-1:0] resolvePc, resolveTarget;
  logic              resolveTaken;

  int checks = 0;
  int errors = 0;

  // reference model state
  logic              mValid [ENTRIES];
  logic [ADDR_W-1:0] mPc    [ENTRIES];
  logic [ADDR_W-1:0] mTgt   [ENTRIES];
  int                mCtr   [ENTRIES];

  always #10 clk = ~clk;  // 50 MHz

  fetch_next_pred #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) dut (
    .clk(clk), .rst(rst), .lookupPc(lookupPc), .hit(hit), .predTaken(predTaken),
    .nextPc(nextPc), .resolveValid(resolveValid), .resolvePc(resolvePc),
    .resolveTarget(resolveTarget), .resolveTaken(resolveTaken)
  );

  function automatic int idxOf(input logic [ADDR_W-1:0] pc);
    return int'(pc[TAG_LO-1:2]);
  endfunction

  function automatic logic sameTag(input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] b);
    return a[ADDR_W-1:TAG_LO] == b[ADDR_W-1:TAG_LO];
  endfunction

  function automatic logic expHit(input logic [ADDR_W-1:0] pc);
    return mValid[idxOf(pc)] && sameTag(mPc[idxOf(pc)], pc);
  endfunction

  function automatic logic expTaken(input logic [ADDR_W-1:0] pc);
    return expHit(pc) && (mCtr[idxOf(pc)] >= 2);
  endfunction

  function automatic logic [ADDR_W-1:0] expNext(input logic [ADDR_W-1:0] pc);
    return expTaken(pc) ? mTgt[idxOf(pc)] : pc + 32'd4;
  endfunction

  task automatic modelClock();
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) mValid[i] = 1'b0;
    end else if (resolveValid) begin
      int k;
      k = idxOf(resolvePc);
      if (expHit(resolvePc)) begin
        if (resolveTaken) begin
          if (mCtr[k] < 3) mCtr[k] = mCtr[k] + 1;
          mTgt[k] = resolveTarget;
        end else if (mCtr[k] > 0) begin
          mCtr[k] = mCtr[k] - 1;
        end
      end else if (resolveTaken) begin
        mValid[k] = 1'b1;
        mPc[k]    = resolvePc;
        mTgt[k]   = resolveTarget;
        mCtr[k]   = 2;
      end
    end
  endtask

  // drive one cycle, check lookup before the edge, advance model at the edge
  task automatic cyc(input logic r, input logic [ADDR_W-1:0] lpc, input logic rv,
                     input logic [ADDR_W-1:0] rpc, input logic [ADDR_W-1:0] rtg,
                     input logic rtk, input string req);
    rst = r; lookupPc = lpc; resolveValid = rv;
    resolvePc = rpc; resolveTarget = rtg; resolveTaken = rtk;
    #3;
    if (!r) begin
      checks++;
      if (hit !== expHit(lpc) || predTaken !== expTaken(lpc) || nextPc !== expNext(lpc)) begin
        errors++;
        $display("FAIL %s pc=%h actual hit=%b tk=%b next=%h expected hit=%b tk=%b next=%h",
                 req, lpc, hit, predTaken, nextPc, expHit(lpc), expTaken(lpc), expNext(lpc));
      end
    end
    @(posedge clk);
    modelClock();
    @(negedge clk);
  endtask

  task automatic look(input logic [ADDR_W-1:0] lpc, input string req);
    cyc(1'b0, lpc, 1'b0, '0, '0, 1'b0, req);
  endtask

  task automatic train(input logic [ADDR_W-1:0] pc, input logic [ADDR_W-1:0] tg,
                       input logic tk, input string req);
    cyc(1'b0, pc, 1'b1, pc, tg, tk, req);
  endtask

  // explicit port-level expectation independent of the model
  task automatic expect3(input logic eh, input logic et, input logic [ADDR_W-1:0] en,
                         input string req);
    checks++;
    if (hit !== eh || predTaken !== et || nextPc !== en) begin
      errors++;
      $display("FAIL %s actual hit=%b tk=%b next=%h expected hit=%b tk=%b next=%h",
               req, hit, predTaken, nextPc, eh, et, en);
    end
  endtask

  initial begin : watchdog
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [ADDR_W-1:0] pA, pB, pC, t1, t2;
    logic [ADDR_W-1:0] pool [8];
    pA = 32'h0000_0100; pB = pA + 32'h40; pC = 32'h0000_2208;
    t1 = 32'h0000_8000; t2 = 32'h0000_9abc;
    for (int i = 0; i < ENTRIES; i++) begin
      mValid[i] = 1'b0; mPc[i] = '0; mTgt[i] = '0; mCtr[i] = 0;
    end
    rst = 1'b1; lookupPc = '0; resolveValid = 1'b0;
    resolvePc = '0; resolveTarget = '0; resolveTaken = 1'b0;
    @(negedge clk);
    cyc(1'b1, pA, 1'b0, '0, '0, 1'b0, "R10");
    cyc(1'b1, pA, 1'b0, '0, '0, 1'b0, "R10");
    #3 expect3(1'b0, 1'b0, pA + 32'd4, "R10 after reset"); #0;
    look(pA, "R1 miss");
    train(pA, t1, 1'b0, "R1");               // R5 not-taken miss
    look(pA, "R5 no allocation");
    train(pA, t1, 1'b1, "R9 same-cycle old");  // allocate, lookup sees old
    #3 expect3(1'b1, 1'b1, t1, "R4 fresh record"); #0;
    look(pA, "R4");
    look(pB, "R2 alias miss");
    train(pA, t2, 1'b0, "R3");                // 10 -> 01
    #3 expect3(1'b1, 1'b0, pA + 32'd4, "R3 hit not predicted"); #0;
    train(pA, t2, 1'b1, "R8");                // 01 -> 10, target t2
    #3 expect3(1'b1, 1'b1, t2, "R8 target refreshed"); #0;
    train(pA, t2, 1'b1, "R6");                // -> 11
    train(pA, t2, 1'b1, "R6 saturate high");  // stays 11
    train(pA, 32'hdead_0000, 1'b0, "R7");     // -> 10
    #3 expect3(1'b1, 1'b1, t2, "R7 one miss keeps taken, R8 target kept"); #0;
    train(pA, 32'hdead_0000, 1'b0, "R7");     // -> 01
    #3 expect3(1'b1, 1'b0, pA + 32'd4, "R7 flips after two"); #0;
    train(pA, t2, 1'b0, "R6");                // -> 00
    train(pA, t2, 1'b0, "R6 saturate low");   // stays 00
    train(pA, t2, 1'b1, "R6");                // -> 01
    #3 expect3(1'b1, 1'b0, pA + 32'd4, "R7 from strong not-taken"); #0;
    train(pB, t1, 1'b1, "R2");                // evict A
    look(pA, "R2 evicted");
    look(pB, "R2 new tag");
    look(pB | 32'h3, "R2 offset bits");
    cyc(1'b1, pA, 1'b1, pC, t1, 1'b1, "R10");
    look(pC, "R10 resolve during reset ignored");
    look(pB, "R10 cleared");

    // random phase over an aliasing pool
    void'($urandom(32'd20240611));
    for (int i = 0; i < 8; i++)
      pool[i] = 32'h0000_1000 + ((i % 3) << 2) + ((i / 3) << TAG_LO);
    for (int n = 0; n < 1500; n++) begin
      logic [ADDR_W-1:0] lp, rp;
      lp = pool[$urandom % 8];
      rp = pool[$urandom % 8];
      cyc(($urandom % 200) == 0, lp, ($urandom % 4) != 0, rp,
          32'h0004_0000 + ($urandom % 64) * 4, ($urandom % 3) != 0,
          expHit(lp) ? (expTaken(lp) ? "R3 random" : "R6 random") : "R1 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule